// File: doc/BRIEF.md
# Window Pulse Shaper

This block is a digital single-channel analyzer for a stream of unsigned signal samples. Each sample that arrives with its valid strobe is compared against two programmable levels. Each comparator reports whether the sample strictly exceeds its level. The two results are combined with exclusive-OR, which gives a flag that is high only while the sample lies between the two levels.

A selectable edge of that in-window flag fires a non-retriggerable one-shot. The one-shot drives a single output pulse whose length is a programmed number of clock cycles. The pulse length does not depend on how long the signal stays inside the window. A length of zero turns the output off.

In use, the block sits after a digitizer. It turns each excursion of the signal into the selected band into one pulse of standard width, which a later counter or timing stage can consume.

Top module: `window_pulse_shaper`

## Requirements
- R1: Each comparator flag is set only when the sample is strictly greater than its level. A sample equal to a level counts as not exceeding it, so a sample equal to the lower level lies outside the window.
- R2: The in-window flag is the exclusive-OR of the two comparator flags. A sample above the lower level and at or below the upper level is inside the window. A sample at or below both levels, or above both, is outside. A jump straight from below both levels to above both levels produces no pulse.
- R3: The window does not depend on which level input holds the smaller value. Swapping the values of `levelA` and `levelB` gives the same pulses.
- R4: With `edgeFall`=0, a valid sample that enters the window at clock edge k makes `pulseOut` high after edge k+1.
- R5: With `edgeFall`=1, the pulse fires when the signal leaves the window, in the same timing as R4. Entering the window produces no pulse in this mode.
- R6: Each pulse stays high for exactly `pulseLen` clock cycles, however long the signal dwells in the window.
- R7: Trigger edges that arrive while a pulse is high are ignored. The one-shot is not retriggerable.
- R8: When `pulseLen` is 0, a trigger edge produces no pulse.
- R9: The length of a pulse is taken from `pulseLen` at the trigger edge. Changing `pulseLen` while a pulse is running does not change that pulse.
- R10: The comparator flags and the window flag change only on clock edges where `sampleValid` is high. Data presented without the strobe has no effect.
- R11: A synchronous active-low reset clears the comparator flags, the edge history and the pulse counter, so `pulseOut` is 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sampleData | input | DATA_W | Unsigned signal sample |
| sampleValid | input | 1 | Sample strobe; the comparators update only when it is high |
| levelA | input | DATA_W | First threshold level |
| levelB | input | DATA_W | Second threshold level |
| pulseLen | input | LEN_W | Output pulse length in clock cycles; 0 disables the output |
| edgeFall | input | 1 | 0: fire on entering the window; 1: fire on leaving it |
| pulseOut | output | 1 | Fixed-length output pulse |

## Verification
The comparator flags register a valid sample at edge k, and the in-window flag reflects it straight away. The edge history lags by one register, so the one-shot loads at edge k+1 and `pulseOut` is first high after that edge. It then stays high for `pulseLen` edges.

The bench drives every input just after a falling clock edge and samples `pulseOut` at the next falling edge. Its behavioural model advances on each rising edge, so each comparison lands half a cycle after the register that produced the value.

Two directed checks confirm the output is still low one cycle after the entering sample and high in the following cycle. Pulse lengths are measured as runs of high cycles across whole pulses.

// File: rtl/wps_pkg.sv
package wps_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic sampleEn;  // capture comparator results
    logic loadCnt;   // start a pulse: load the length
    logic decCnt;    // pulse running: count down
  } ctlStrobes_t;
endpackage

// File: rtl/wps_datapath.sv
module wps_datapath
  import wps_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [DATA_W-1:0] levelA,
  input  logic [DATA_W-1:0] levelB,
  input  logic [LEN_W-1:0]  pulseLen,
  output logic              winFlag,
  output logic              riseEv,
  output logic              fallEv,
  output logic              busy,
  output logic              lenZero,
  output logic [LEN_W-1:0]  pulseCnt
);
  localparam int NUM_CMP = 2;

  logic [NUM_CMP-1:0][DATA_W-1:0] refLvl;
  logic [NUM_CMP-1:0]             cmpNext;
  logic [NUM_CMP-1:0]             cmpHit;
  logic                           winPrev;

  assign refLvl[0] = levelA;
  assign refLvl[1] = levelB;

  // One strict comparator per level
  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    assign cmpNext[gi] = (sampleData > refLvl[gi]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpHit <= '0;
    end else if (strobes.sampleEn) begin
      cmpHit <= cmpNext;
    end
  end

  // Exclusive-OR of the comparators marks the band between the levels
  assign winFlag = ^cmpHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winPrev <= 1'b0;
    end else begin
      winPrev <= winFlag;
    end
  end

  assign riseEv = winFlag & ~winPrev;
  assign fallEv = ~winFlag & winPrev;

  // Pulse length counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulseCnt <= '0;
    end else if (strobes.loadCnt) begin
      pulseCnt <= pulseLen;
    end else if (strobes.decCnt) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign busy    = |pulseCnt;
  assign lenZero = (pulseLen == '0);
endmodule

// File: rtl/wps_ctrl.sv
module wps_ctrl
  import wps_pkg::*;
(
  input  logic        sampleValid,
  input  logic        edgeFall,
  input  logic        riseEv,
  input  logic        fallEv,
  input  logic        busy,
  input  logic        lenZero,
  output ctlStrobes_t strobes
);
  logic trigger;

  assign trigger = edgeFall ? fallEv : riseEv;

  always_comb begin
    strobes          = '0;
    strobes.sampleEn = sampleValid;
    // A running pulse has priority: edges during it are dropped
    strobes.decCnt   = busy;
    strobes.loadCnt  = trigger & ~busy & ~lenZero;
  end
endmodule

// File: rtl/window_pulse_shaper.sv
module window_pulse_shaper
  import wps_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] levelA,
  input  logic [DATA_W-1:0] levelB,
  input  logic [LEN_W-1:0]  pulseLen,
  input  logic              edgeFall,
  output logic              pulseOut
);
  ctlStrobes_t      strobes;
  logic             winFlag;
  logic             riseEv;
  logic             fallEv;
  logic             busy;
  logic             lenZero;
  logic [LEN_W-1:0] pulseCnt;

  wps_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .sampleData (sampleData),
    .levelA     (levelA),
    .levelB     (levelB),
    .pulseLen   (pulseLen),
    .winFlag    (winFlag),
    .riseEv     (riseEv),
    .fallEv     (fallEv),
    .busy       (busy),
    .lenZero    (lenZero),
    .pulseCnt   (pulseCnt)
  );

  wps_ctrl u_ctrl (
    .sampleValid (sampleValid),
    .edgeFall    (edgeFall),
    .riseEv      (riseEv),
    .fallEv      (fallEv),
    .busy        (busy),
    .lenZero     (lenZero),
    .strobes     (strobes)
  );

  assign pulseOut = busy;
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
  parameter int DATA_W = 12,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] sampleData,
  input logic              sampleValid,
  input logic [DATA_W-1:0] levelA,
  input logic [DATA_W-1:0] levelB,
  input logic [LEN_W-1:0]  pulseLen,
  input logic              pulseOut,
  input logic              winFlag,
  input logic [LEN_W-1:0]  pulseCnt
);
  logic [DATA_W-1:0] loLvl;
  logic [DATA_W-1:0] hiLvl;
  logic              inBand;

  always_comb begin
    loLvl  = (levelA < levelB) ? levelA : levelB;
    hiLvl  = (levelA < levelB) ? levelB : levelA;
    inBand = (sampleData > loLvl) && (sampleData <= hiLvl);
  end

  assert_window_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid && inBand |=> winFlag);

  // Covers R1 (equality is outside) and R3 (order of levels)
  assert_window_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid && !inBand |=> !winFlag);

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(winFlag));

  assert_len_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulseOut) |-> pulseCnt == $past(pulseLen));

  assert_no_retrig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulseOut && pulseCnt > 1 |=> pulseOut && pulseCnt == $past(pulseCnt) - 1'b1);

  assert_len_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pulseOut && pulseLen == '0 |=> !pulseOut);

  assert_reset_R11: assert property (@(posedge clk)
    !rst_n |=> !pulseOut && !winFlag);
endmodule

bind window_pulse_shaper wps_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sampleData  (sampleData),
  .sampleValid (sampleValid),
  .levelA      (levelA),
  .levelB      (levelB),
  .pulseLen    (pulseLen),
  .pulseOut    (pulseOut),
  .winFlag     (winFlag),
  .pulseCnt    (pulseCnt)
);

// File: tb/window_pulse_shaper_tb.sv
`timescale 1ns/1ps
module window_pulse_shaper_tb;
  localparam int DATA_W = 12;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic              sampleValid = 1'b0;
  logic [DATA_W-1:0] levelA = 12'd100;
  logic [DATA_W-1:0] levelB = 12'd200;
  logic [LEN_W-1:0]  pulseLen = 8'd5;
  logic              edgeFall = 1'b0;
  logic              pulseOut;

  always #2 clk = ~clk;  // 250 MHz

  window_pulse_shaper #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sampleData(sampleData), .sampleValid(sampleValid),
    .levelA(levelA), .levelB(levelB), .pulseLen(pulseLen), .edgeFall(edgeFall),
    .pulseOut(pulseOut)
  );

  int    errors = 0;
  int    checks = 0;
  string curReq = "R11";
  bit    done = 0;

  // Behavioural reference: band membership from sorted levels, pulse as remaining cycles
  bit mIn, mPrevIn;
  int mLeft;
  always @(posedge clk) begin
    if (!rst_n) begin
      mIn = 0; mPrevIn = 0; mLeft = 0;
    end else begin
      bit trig;
      trig = edgeFall ? (!mIn && mPrevIn) : (mIn && !mPrevIn);
      if (mLeft > 0) mLeft = mLeft - 1;
      else if (trig && pulseLen != 0) mLeft = int'(pulseLen);
      mPrevIn = mIn;
      if (sampleValid) begin
        int lo, hi;
        lo = (levelA < levelB) ? int'(levelA) : int'(levelB);
        hi = (levelA < levelB) ? int'(levelB) : int'(levelA);
        mIn = (int'(sampleData) > lo) && (int'(sampleData) <= hi);
      end
    end
  end

  // Per-cycle comparison and pulse measurement
  int  pulsesTotal = 0;
  int  runLen = 0;
  int  lastLen = 0;
  bit  prevOut = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pulseOut !== (mLeft > 0)) begin
        errors++;
        $display("FAIL %s: per-cycle pulseOut=%0b expected %0b at %0t",
                 curReq, pulseOut, (mLeft > 0), $time);
      end
    end
    if (pulseOut && !prevOut) pulsesTotal++;
    if (pulseOut) runLen++;
    else if (prevOut) begin lastLen = runLen; runLen = 0; end
    prevOut = pulseOut;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(input int v, input int n);
    for (int i = 0; i < n; i++) begin
      sampleData = v[DATA_W-1:0];
      sampleValid = 1'b1;
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    idle(3);
    check("R11 reset", int'(pulseOut), 0);
    rst_n = 1'b1;
    feed(50, 3);

    // R1: equal to lower level stays outside
    curReq = "R1"; base = pulsesTotal;
    feed(100, 5); idle(8);
    check("R1 equal-to-level count", pulsesTotal - base, 0);

    // R4: entry timing
    curReq = "R4"; base = pulsesTotal;
    sampleData = 12'd101; sampleValid = 1'b1;
    @(negedge clk);
    check("R4 low one cycle after entry", int'(pulseOut), 0);
    @(negedge clk);
    check("R4 high two cycles after entry", int'(pulseOut), 1);
    feed(101, 20); feed(50, 3); idle(10);
    curReq = "R6";
    check("R4 entry count", pulsesTotal - base, 1);
    check("R6 width with long dwell", lastLen, 5);

    // R2: jump over the window, then upper level is inside
    curReq = "R2"; base = pulsesTotal;
    feed(250, 4); feed(50, 4); idle(8);
    check("R2 jump across count", pulsesTotal - base, 0);
    base = pulsesTotal;
    feed(200, 2); feed(50, 2); idle(8);
    check("R2 upper-level inside count", pulsesTotal - base, 1);

    // R3: swapped levels
    curReq = "R3"; levelA = 12'd200; levelB = 12'd100; base = pulsesTotal;
    feed(150, 3); feed(50, 3); idle(8);
    check("R3 swapped count", pulsesTotal - base, 1);
    check("R3 swapped width", lastLen, 5);
    levelA = 12'd100; levelB = 12'd200;

    // R5: falling edge mode
    curReq = "R5"; edgeFall = 1'b1; base = pulsesTotal;
    feed(150, 10);
    check("R5 no pulse on entry", pulsesTotal - base, 0);
    feed(50, 3); idle(8);
    check("R5 pulse on exit", pulsesTotal - base, 1);
    // ramp up then down: two exits
    pulseLen = 8'd3; base = pulsesTotal;
    for (int v = 0; v <= 300; v += 5) feed(v, 1);
    for (int v = 300; v >= 0; v -= 5) feed(v, 1);
    idle(8);
    check("R5 ramp exits", pulsesTotal - base, 2);
    check("R6 ramp width", lastLen, 3);
    edgeFall = 1'b0;

    // R7: re-entry during a pulse is ignored
    curReq = "R7"; pulseLen = 8'd20; base = pulsesTotal;
    feed(150, 1); feed(250, 1); feed(150, 1); feed(50, 1); idle(30);
    check("R7 re-entry count", pulsesTotal - base, 1);
    check("R7 width", lastLen, 20);

    // R8: zero length disables
    curReq = "R8"; pulseLen = 8'd0; base = pulsesTotal;
    feed(150, 3); feed(50, 3); idle(6);
    check("R8 zero length count", pulsesTotal - base, 0);

    // R9: length captured at trigger
    curReq = "R9"; pulseLen = 8'd6; base = pulsesTotal;
    feed(150, 1); idle(3);
    pulseLen = 8'd30;
    feed(50, 2); idle(40);
    check("R9 width kept", lastLen, 6);
    check("R9 count", pulsesTotal - base, 1);

    // R10: data without strobe is ignored
    curReq = "R10"; pulseLen = 8'd4; base = pulsesTotal;
    sampleData = 12'd150; sampleValid = 1'b0; idle(10);
    check("R10 unstrobed count", pulsesTotal - base, 0);
    feed(150, 1); idle(8);
    check("R10 strobed count", pulsesTotal - base, 1);
    feed(50, 2);

    // Sine-like sequence against the model
    curReq = "R2 sine"; base = pulsesTotal;
    for (int i = 0; i < 300; i++) begin
      feed(150 + $rtoi(130.0 * $sin(i * 0.15)), 1);
      if (i % 7 == 3) idle(1);
    end
    idle(10);
    checks++;
    if (pulsesTotal - base < 2) begin
      errors++;
      $display("FAIL R2 sine: actual=%0d expected>=2", pulsesTotal - base);
    end

    // R11: reset during a pulse
    curReq = "R11"; pulseLen = 8'd40;
    feed(150, 1); idle(3);
    rst_n = 1'b0; @(negedge clk);
    check("R11 mid-pulse reset", int'(pulseOut), 0);
    rst_n = 1'b1; feed(50, 2); idle(4);
    check("R11 after reset", int'(pulseOut), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule